// File: doc/BRIEF.md
# Timer with Compare-Triggered Clear

This block is a 16-bit up-counter with a selectable clock source, a power-of-two prescaler and a 16-bit compare pair. It counts either every core clock cycle or on rising edges of an external count pin. The count pin can run through a two-flop synchronizer or in an asynchronous mode. When the counter passes 16'hFFFF it sets a sticky overflow flag, which software clears over a byte-wide register bus.

When the compare mode field holds the event code 4'b1011, the counter is compared with the compare pair after each increment. When the incremented value equals the pair, the counter loads zero and a one-cycle trigger pulse is issued. The compare pair therefore acts as a period register: the counter cycles through 0 .. N-1 for a compare value N. A bus write to a counter byte in that same cycle overrides the clear.

A small run-mode state machine is decoded from the control register and updates on the same edge as the register. Its states are ST_OFF (timer disabled), ST_INTCLK (counting core clock cycles), ST_EXT_SYNC (counting synchronized external edges) and ST_EXT_ASYNC (external edges, asynchronous mode). Every state can move to every other one on any control write: the transition to ST_OFF happens when the enable bit is written 0. The transition to ST_INTCLK happens when enable is 1 and source is 0. The transitions to ST_EXT_SYNC and ST_EXT_ASYNC happen when enable and source are both 1, with the asynchronous bit 0 or 1 respectively.

Top module: `tmr_cmp_top`

## Requirements
- R1: While rst_n is low and after its release, the control register, both compare bytes, the mode field and the overflow flag read 0, and trig_pulse is 0.
- R2: Register addresses: 0 control, 1 counter low byte, 2 counter high byte, 3 compare low byte, 4 compare high byte, 5 compare mode in bits 3:0, 6 overflow flag in bit 0, 7 reads 0. Reads are combinational from bus_addr. Writes take effect on the clock edge where bus_wr is high.
- R3: Control bits: bit 0 enable, bit 1 source (0 core clock, 1 count pin), bit 2 asynchronous select, bit 3 oscillator enable (stored only), bits 5:4 prescale select. Bits 7:6 always read 0.
- R4: Prescale select values 0, 1, 2 and 3 advance the counter once per 1, 2, 4 and 8 counting events.
- R5: With the count pin as source and no prescale, a rising pin level first sampled at clock edge k increments the counter at edge k+2.
- R6: A write to a counter byte loads that byte and keeps the other one. It clears the prescaler and discards any increment in that cycle.
- R7: An increment from 16'hFFFF sets the overflow flag. The flag stays 1 until a write of 0 to bit 0 of address 6. A set in the same cycle as that write wins.
- R8: With mode 4'b1011 and the source not asynchronous, an increment whose result equals the compare pair loads 0 instead. trig_pulse is 1 for the cycle after that edge.
- R9: The compare clear never sets the overflow flag. Only a rollover from 16'hFFFF does.
- R10: In the asynchronous external mode the compare match produces no clear and no pulse.
- R11: A counter-byte write in the same cycle as a compare match loads the written byte. The other byte is kept, the clear is dropped and the trigger pulse is still issued.
- R12: Any mode code other than 4'b1011 produces no clear and no pulse.
- R13: The counter bytes are not cleared by rst_n and keep their value across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on/brown-out reset, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_in | input | 1 | External count pin |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| trig_pulse | output | 1 | One-cycle compare event pulse |

## Verification
The counting path is driven with the core clock at every prescale ratio and with the count pin toggled in both slow and back-to-back patterns. This separates the synchronizer latency from the prescaler division. The compare path is run with the event code, with a neighbouring non-event code and in the asynchronous mode. Only the first should wrap the counter at the compare value, so a wrong mode decode becomes visible. Rollover is driven from just below 16'hFFFF, both with and without the event mode, to separate the flag from the clear. A counter write is placed exactly on a match edge to show which update wins.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_INTCLK,
        ST_EXT_SYNC,
        ST_EXT_ASYNC
    } run_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_FLAG   = 3'd6;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_SRC_BIT   = 1;
    localparam int CTRL_ASYNC_BIT = 2;
    localparam int CTRL_PS_LSB    = 4;
    localparam logic [7:0] CTRL_MASK = 8'h3F;

    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_EVENT = 4'b1011;
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] ctrl_q,
    output run_state_e       state_q
);
    logic [BUS_W-1:0] ctrl_d;
    run_state_e       state_d;

    always_comb begin
        ctrl_d = ctrl_we ? (wdata & BUS_W'(CTRL_MASK)) : ctrl_q;
    end

    // next run state follows the value the control register takes
    always_comb begin
        unique case ({ctrl_d[CTRL_EN_BIT], ctrl_d[CTRL_SRC_BIT], ctrl_d[CTRL_ASYNC_BIT]})
            3'b100, 3'b101: state_d = ST_INTCLK;
            3'b110:         state_d = ST_EXT_SYNC;
            3'b111:         state_d = ST_EXT_ASYNC;
            default:        state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/tmr_tick.sv
`timescale 1ns/1ps
module tmr_tick
    import tmr_pkg::*;
#(
    parameter int PS_W   = 2,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_in,
    input  run_state_e      state_q,
    input  logic [PS_W-1:0] ps_sel,
    input  logic            pre_clr,
    output logic            tick
);
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [SYNC_N:0]  sync_q;
    logic             ext_edge;
    logic             event_ok;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-1:0], cnt_in};
        end
    end

    assign ext_edge = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

    always_comb begin
        unique case (state_q)
            ST_OFF:       event_ok = 1'b0;
            ST_INTCLK:    event_ok = 1'b1;
            ST_EXT_SYNC:  event_ok = ext_edge;
            ST_EXT_ASYNC: event_ok = ext_edge;
        endcase
    end

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            pre_lim[i] = (i < int'(ps_sel));
        end
    end

    assign tick = event_ok && (pre_q == pre_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (pre_clr) begin
            pre_q <= '0;
        end else if (event_ok) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
    import tmr_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int NBYTES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  run_state_e              state_q,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BUS_W-1:0]        bus_wdata,
    output logic [NBYTES*BUS_W-1:0] cnt_q,
    output logic [NBYTES*BUS_W-1:0] cmp_q,
    output logic [MODE_W-1:0]       mode_q,
    output logic                    flag_q,
    output logic                    trig_q,
    output logic                    cnt_wr
);
    localparam int CNT_W = NBYTES * BUS_W;

    logic [NBYTES-1:0] cnt_we;
    logic [NBYTES-1:0] cmp_we;
    logic [CNT_W-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              match;
    logic              wrap;
    logic              inc_apply;

    for (genvar b = 0; b < NBYTES; b++) begin : g_we
        assign cnt_we[b] = bus_wr && (bus_addr == ADDR_W'(ADDR_CNT_LO + b));
        assign cmp_we[b] = bus_wr && (bus_addr == ADDR_W'(ADDR_CMP_LO + b));
    end

    assign cnt_wr    = |cnt_we;
    assign inc_apply = tick && !cnt_wr;
    assign cnt_inc   = cnt_q + CNT_W'(1);
    assign wrap      = tick && (cnt_q == {CNT_W{1'b1}});
    assign match     = tick && (mode_q == MODE_EVENT)
                       && (state_q != ST_EXT_ASYNC) && (cnt_inc == cmp_q);
    assign cnt_nxt   = match ? '0 : cnt_inc;

    // counter bytes carry no reset
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBYTES; b++) begin
            if (cnt_we[b]) begin
                cnt_q[b*BUS_W +: BUS_W] <= bus_wdata;
            end else if (inc_apply) begin
                cnt_q[b*BUS_W +: BUS_W] <= cnt_nxt[b*BUS_W +: BUS_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= '0;
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (cmp_we[b]) begin
                    cmp_q[b*BUS_W +: BUS_W] <= bus_wdata;
                end
            end
            if (bus_wr && bus_addr == ADDR_MODE) begin
                mode_q <= bus_wdata[MODE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= match;
            if (wrap && !cnt_wr) begin
                flag_q <= 1'b1;
            end else if (bus_wr && bus_addr == ADDR_FLAG) begin
                flag_q <= bus_wdata[0];
            end
        end
    end
endmodule

// File: rtl/tmr_cmp_top.sv
`timescale 1ns/1ps
module tmr_cmp_top
    import tmr_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int NBYTES = 2,
    parameter int PS_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cnt_in,
    output logic             ovf_flag,
    output logic             trig_pulse
);
    localparam int CNT_W = NBYTES * BUS_W;

    logic [BUS_W-1:0]  ctrl_val;
    run_state_e        run_state;
    logic              tick;
    logic              cnt_wr;
    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  cmp_val;
    logic [MODE_W-1:0] mode_val;

    tmr_ctrl #(.BUS_W(BUS_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (bus_wr && bus_addr == ADDR_CTRL),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_val),
        .state_q (run_state)
    );

    tmr_tick #(.PS_W(PS_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_in  (cnt_in),
        .state_q (run_state),
        .ps_sel  (ctrl_val[CTRL_PS_LSB +: PS_W]),
        .pre_clr (cnt_wr),
        .tick    (tick)
    );

    tmr_core #(.BUS_W(BUS_W), .NBYTES(NBYTES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .state_q   (run_state),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_q     (cnt_val),
        .cmp_q     (cmp_val),
        .mode_q    (mode_val),
        .flag_q    (ovf_flag),
        .trig_q    (trig_pulse),
        .cnt_wr    (cnt_wr)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata = ctrl_val;
        end
        for (int b = 0; b < NBYTES; b++) begin
            if (bus_addr == ADDR_W'(ADDR_CNT_LO + b)) bus_rdata = cnt_val[b*BUS_W +: BUS_W];
            if (bus_addr == ADDR_W'(ADDR_CMP_LO + b)) bus_rdata = cmp_val[b*BUS_W +: BUS_W];
        end
        if (bus_addr == ADDR_MODE) begin
            bus_rdata = BUS_W'(mode_val);
        end
        if (bus_addr == ADDR_FLAG) begin
            bus_rdata = BUS_W'(ovf_flag);
        end
    end
endmodule

// File: rtl/tmr_cmp_checker.sv
`timescale 1ns/1ps
module tmr_cmp_checker #(
    parameter int BUS_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic             flag_wbit,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             trig_pulse,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] cnt_val,
    input logic             ctrl_en,
    input logic             ctrl_src,
    input logic             ctrl_async,
    input logic [3:0]       mode_val
);
    logic cnt_write;
    logic flag_write;
    assign cnt_write  = bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd2);
    assign flag_write = bus_wr && bus_addr == 3'd6 && flag_wbit;

    // R8: a trigger follows a clear to zero unless a byte write intervened
    assert_trig_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse && !$past(cnt_write) |-> cnt_val == '0);

    // R10, R12: trigger only under the event code and a non-async source
    assert_trig_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> ($past(mode_val) == 4'b1011)
                       && !($past(ctrl_src) && $past(ctrl_async)));

    // R7, R9: the flag rises only from a rollover or a software set
    assert_flag_rollover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) && !$past(flag_write) |-> $past(cnt_val) == {CNT_W{1'b1}});

    // R3: top control bits read as zero
    assert_ctrl_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 3'd0 |-> bus_rdata[BUS_W-1:BUS_W-2] == 2'b00);

    // R6, R3: a disabled timer with no byte write holds its count
    assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_en) && !$past(cnt_write) |-> cnt_val == $past(cnt_val));
endmodule

bind tmr_cmp_top tmr_cmp_checker #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .flag_wbit  (bus_wdata[0]),
    .bus_rdata  (bus_rdata),
    .trig_pulse (trig_pulse),
    .ovf_flag   (ovf_flag),
    .cnt_val    (cnt_val),
    .ctrl_en    (ctrl_val[0]),
    .ctrl_src   (ctrl_val[1]),
    .ctrl_async (ctrl_val[2]),
    .mode_val   (mode_val)
);

// File: tb/tmr_cmp_top_bench.sv
`timescale 1ns/1ps
module tmr_cmp_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_wr = 1'b0;
    logic [2:0] b_addr = 3'd0;
    logic [7:0] b_wdata = 8'h00;
    logic       cnt_in = 1'b0;
    logic [7:0] rdata;
    logic       ovf_flag;
    logic       trig_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_cmp_top u_tmr_cmp_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (b_wr),
        .bus_addr   (b_addr),
        .bus_wdata  (b_wdata),
        .bus_rdata  (rdata),
        .cnt_in     (cnt_in),
        .ovf_flag   (ovf_flag),
        .trig_pulse (trig_pulse)
    );

    // behavioural reference state
    int m_ctrl, m_cmp, m_mode, m_flag, m_trig, m_pre, m_cnt;
    bit lo_known = 0, hi_known = 0;
    int s1, s2, s3;
    int en, src, asy, ps, lim, ev, tk, cw, nxt, ntrig, oset;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_ctrl;
            1: return m_cnt & 'hFF;
            2: return (m_cnt >> 8) & 'hFF;
            3: return m_cmp & 'hFF;
            4: return (m_cmp >> 8) & 'hFF;
            5: return m_mode;
            6: return m_flag;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cmp = 0; m_mode = 0; m_flag = 0; m_trig = 0; m_pre = 0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            en  = m_ctrl & 1;
            src = (m_ctrl >> 1) & 1;
            asy = src & ((m_ctrl >> 2) & 1);
            ps  = (m_ctrl >> 4) & 3;
            lim = (1 << ps) - 1;
            ev  = en ? (src ? (s2 && !s3) : 1) : 0;
            tk  = ev && (m_pre == lim);
            cw  = b_wr && (b_addr == 1 || b_addr == 2);
            if (cw) m_pre = 0;
            else if (ev) m_pre = tk ? 0 : m_pre + 1;
            ntrig = 0; oset = 0; nxt = 0;
            if (tk && lo_known && hi_known) begin
                nxt = (m_cnt + 1) % 65536;
                if (m_mode == 'hB && !asy && nxt == m_cmp) ntrig = 1;
            end
            if (cw) begin
                if (b_addr == 1) begin m_cnt = (m_cnt & 'hFF00) | b_wdata; lo_known = 1; end
                else begin m_cnt = (m_cnt & 'h00FF) | (b_wdata << 8); hi_known = 1; end
            end else if (tk && lo_known && hi_known) begin
                if (m_cnt == 'hFFFF) oset = 1;
                m_cnt = ntrig ? 0 : nxt;
            end
            m_trig = ntrig;
            if (oset) m_flag = 1;
            else if (b_wr && b_addr == 6) m_flag = b_wdata & 1;
            if (b_wr && b_addr == 0) m_ctrl = b_wdata & 'h3F;
            if (b_wr && b_addr == 3) m_cmp = (m_cmp & 'hFF00) | b_wdata;
            if (b_wr && b_addr == 4) m_cmp = (m_cmp & 'h00FF) | (b_wdata << 8);
            if (b_wr && b_addr == 5) m_mode = b_wdata & 'hF;
            s3 = s2; s2 = s1; s1 = cnt_in;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 trigger", trig_pulse, m_trig);
            chk("R7 flag", ovf_flag, m_flag);
            if (b_addr == 1 || b_addr == 2) begin
                if (lo_known && hi_known) chk("R4 count read", rdata, model_read(b_addr));
            end else begin
                chk("R2 register read", rdata, model_read(b_addr));
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        b_wr = 1; b_addr = 3'(a); b_wdata = 8'(d);
        @(negedge clk); #1;
        b_wr = 0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk); #1;
        b_addr = 3'(a);
        @(negedge clk);
        chk(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_cnt(input int v);
        wr(1, v & 'hFF);
        wr(2, (v >> 8) & 'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 trig in reset", trig_pulse, 0);
        #1 rst_n = 1;
        // R1 reset values
        rd(0, 0, "R1 ctrl"); rd(3, 0, "R1 cmp lo"); rd(4, 0, "R1 cmp hi");
        rd(5, 0, "R1 mode"); rd(6, 0, "R1 flag"); rd(7, 0, "R2 unused");
        // R3 control masking
        wr(0, 'hFF); rd(0, 'h3F, "R3 ctrl mask");
        wr(0, 'h08); rd(0, 'h08, "R3 osc bit");
        wr(0, 'h00);
        // R6 byte loads, R13 retention
        set_cnt('h1234); rd(1, 'h34, "R6 lo"); rd(2, 'h12, "R6 hi");
        wr(1, 'hAB); rd(2, 'h12, "R6 other byte kept");
        set_cnt('hBEEF);
        @(negedge clk); #1 rst_n = 0;
        idle(2); rst_n = 1;
        rd(1, 'hEF, "R13 lo kept"); rd(2, 'hBE, "R13 hi kept");
        // R4 prescale ratios on the core clock
        for (int p = 0; p < 4; p++) begin
            set_cnt(0); wr(0, (p << 4) | 1); idle(24); wr(0, 0);
            rd(1, model_read(1), "R4 prescale result");
        end
        // R5 synchronizer latency
        set_cnt(0); wr(0, 'h03);
        b_addr = 1;
        @(negedge clk); #1 cnt_in = 1;
        @(negedge clk); chk("R5 edge k", rdata, 0);
        @(negedge clk); chk("R5 edge k+1", rdata, 0);
        @(negedge clk); chk("R5 edge k+2", rdata, 1);
        #1 cnt_in = 0;
        // R4 external edges, several patterns and prescale 2
        for (int r = 0; r < 12; r++) begin
            idle(r % 3 + 1); cnt_in = 1; idle(r % 2 + 1); cnt_in = 0;
        end
        wr(0, 'h13);
        for (int r = 0; r < 10; r++) begin idle(2); cnt_in = ~cnt_in; end
        idle(4); wr(0, 0);
        // R7 overflow and sticky flag, set wins
        set_cnt('hFFFD); wr(0, 1); idle(6); wr(0, 0);
        rd(6, 1, "R7 flag set");
        idle(3); rd(6, 1, "R7 flag sticky");
        wr(6, 0); rd(6, 0, "R7 flag cleared");
        // R8 period behaviour with event code
        wr(3, 5); wr(4, 0); wr(5, 'hB); set_cnt(0);
        wr(0, 1); idle(30); wr(0, 0);
        chk("R9 no flag from clear", ovf_flag, 0);
        // R9 rollover with event code still sets flag via rollover only
        wr(3, 0); wr(4, 0); set_cnt('hFFFE); wr(0, 1); idle(4); wr(0, 0);
        rd(6, 1, "R9 rollover sets flag"); wr(6, 0);
        // R12 neighbouring code: counter runs past compare
        wr(3, 5); wr(5, 'hA); set_cnt(0); wr(0, 1); idle(12); wr(0, 0);
        rd(1, model_read(1), "R12 no clear");
        chk("R12 count past compare", (model_read(1) > 5) ? 1 : 0, 1);
        // R10 asynchronous external mode ignores match
        wr(5, 'hB); set_cnt(0); wr(0, 'h07);
        for (int r = 0; r < 10; r++) begin idle(3); cnt_in = 1; idle(3); cnt_in = 0; end
        wr(0, 0);
        rd(1, 10, "R10 no clear async");
        // R8 synchronized external with event code
        set_cnt(0); wr(0, 'h03);
        for (int r = 0; r < 12; r++) begin idle(3); cnt_in = 1; idle(3); cnt_in = 0; end
        wr(0, 0);
        rd(1, 2, "R8 wrapped at compare");
        // R11 write coinciding with match
        set_cnt(4); b_addr = 1;
        @(negedge clk); #1 b_wr = 1; b_addr = 0; b_wdata = 8'h01;
        @(negedge clk); #1 b_addr = 1; b_wdata = 8'h55;
        @(negedge clk);
        chk("R11 trigger still issued", trig_pulse, 1);
        chk("R11 write wins", rdata, 'h55);
        #1 b_addr = 0; b_wdata = 8'h00;
        @(negedge clk); #1 b_wr = 0;
        rd(2, 0, "R11 high byte kept");
        idle(4);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule